// File: doc/BRIEF.md
# Byte-lane static memory with width-mode select

This block is a synthesizable model of an asynchronous static memory with a 16-bit data bus, sampled on a system clock. Its control pins are two chip enables of opposite polarity, an active-low output enable, an active-low write enable and two active-low byte-lane enables. The enables for the low lane and the high lane gate each half of the word independently for both reads and writes. The bidirectional bus is split into a data-in port, a registered data-out port and one output-enable bit per lane. A pad ring or a bench can then rebuild the tri-state bus from those three signals.

A static mode pin selects the organization. With the pin high, the memory holds 16-bit words, and the normal address bits select the word. With the pin low, the memory holds twice as many bytes. Data-in bit 15 then serves as the least significant byte-address bit and selects the low or high half of the addressed word. Byte data travels on bits 7:0. In this mode the lane enables and data-in bits 14:8 have no effect.

An access-state machine runs with four states:
- `ST_STANDBY`: deselected, or in word mode with both lane enables high.
- `ST_IDLE`: selected, with no read or write.
- `ST_READ`: selected, output enable low and write enable high.
- `ST_WRITE`: selected with write enable low.

Every clock edge moves the machine directly to the state that the sampled pins call for. Any state can go to any state:
- `go_sleep` leads to `ST_STANDBY`.
- `go_write` leads to `ST_WRITE`.
- `go_read` leads to `ST_READ`.
- Otherwise the machine goes to `ST_IDLE`.

Reset places the machine in `ST_STANDBY`. The array depth is a parameter and is kept small for simulation.

Top module: `sram_bytelane_top`

## Requirements
- R1: The device is selected only when `cs1_n`=0 and `cs2`=1. In any other combination no location is written, `dout_en` is 00 and `standby` is 1 after the next clock edge.
- R2: In word mode, a selected write with `we_n`=0 commits at the clock edge. Bits 7:0 of `din` are written only if `lo_n`=0, and bits 15:8 only if `hi_n`=0. A lane whose enable is high keeps its old contents.
- R3: In word mode, a selected read (`oe_n`=0, `we_n`=1) presents the stored word on `dout` one clock edge after the pins are sampled. Bit 0 of `dout_en` marks the low lane as driven, and bit 1 marks the high lane. A lane is driven only if its enable is low. The `dout` bits of an undriven lane are 0.
- R4: `dout_en` is 00 after any edge at which the pins showed any of these: deselected, `oe_n`=1, both lane enables high in word mode, or a write in progress.
- R5: `standby` is 1 during the cycle after an edge at which the device was deselected, or was in word mode with `lo_n`=`hi_n`=1. Otherwise it is 0.
- R6: With `wide_mode`=1, `addr` selects one 16-bit word out of 2^ADDR_W words.
- R7: With `wide_mode`=0, the byte address is {`addr`, `din[15]`}. `din[15]`=0 selects bits 7:0 of the word at `addr`, and 1 selects bits 15:8. Byte writes take data from `din[7:0]`, and byte reads return data on `dout[7:0]`.
- R8: With `wide_mode`=0, `lo_n`, `hi_n` and `din[14:8]` have no effect. A read gives `dout_en`=01 and `dout[15:8]`=0. A selected device is not in standby.
- R9: When the write and read conditions hold together (`oe_n`=0, `we_n`=0), the write is performed and `dout_en` stays 00.
- R10: While `rst_n` is low, `dout` is 0, `dout_en` is 00 and `standby` is 1. Memory contents after reset are undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lo_n | input | 1 | Low-lane enable, active low (bits 7:0) |
| hi_n | input | 1 | High-lane enable, active low (bits 15:8) |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data; bit 15 is the byte-address bit in byte mode |
| dout | output | 16 | Registered read data |
| dout_en | output | 2 | Per-lane drive enable (bit 0 low lane, bit 1 high lane) |
| standby | output | 1 | Standby indicator |

## Verification
On every cycle, the assertions check the gating rules that relate one edge's pins to the next cycle's outputs:
- deselect, output-enable high, write-in-progress and both-lanes-off all silence the outputs;
- each lane enable gates its own lane;
- byte mode never drives the high lane and never reports standby while selected;
- an undriven lane always reads zero.

Only the bench's scenarios can show that data is stored and returned correctly. These scenarios sweep the whole array in both modes and check partial-lane writes that preserve the other half. They also check that byte addresses map onto word halves in the stated order, and that writes blocked by deselection leave the contents unchanged.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;

    // Lane geometry of the 16-bit bus
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    // Access state sampled at each clock edge
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } acc_state_t;

endpackage

// File: rtl/sram_bl_decode.sv
module sram_bl_decode
    import sram_bl_pkg::*;
(
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] din,
    output logic [LANES-1:0]  lane_wr,
    output logic [LANES-1:0]  lane_rd,
    output logic [DATA_W-1:0] wr_data,
    output logic              half_sel,
    output logic              go_sleep,
    output logic              go_write,
    output logic              go_read
);

    logic             selected;
    logic             wr_cond;
    logic             rd_cond;
    logic [LANES-1:0] wide_lanes;
    logic [LANES-1:0] byte_wr_lanes;
    logic [LANES-1:0] byte_rd_lanes;

    assign selected = !cs1_n && cs2;
    assign wr_cond  = selected && !we_n;
    assign rd_cond  = selected && !oe_n && we_n;

    // Word mode: lane requests come from the active-low lane enables
    assign wide_lanes = {!hi_n, !lo_n};

    // Byte mode: top data bit picks the half; byte travels on lane 0
    always_comb begin
        byte_wr_lanes = '0;
        byte_wr_lanes[din[DATA_W-1]] = 1'b1;
        byte_rd_lanes = '0;
        byte_rd_lanes[0] = 1'b1;
    end

    always_comb begin
        if (wide_mode) begin
            wr_data  = din;
            half_sel = 1'b0;
            lane_wr  = wr_cond ? wide_lanes : '0;
            lane_rd  = rd_cond ? wide_lanes : '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                wr_data[i*LANE_W +: LANE_W] = din[LANE_W-1:0];
            end
            half_sel = din[DATA_W-1];
            lane_wr  = wr_cond ? byte_wr_lanes : '0;
            lane_rd  = rd_cond ? byte_rd_lanes : '0;
        end
    end

    assign go_sleep = !selected || (wide_mode && lo_n && hi_n);
    assign go_write = wr_cond;
    assign go_read  = rd_cond;

endmodule

// File: rtl/sram_bl_array.sv
module sram_bl_array
    import sram_bl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    // One independent storage column per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) begin
                cells[addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sram_bl_fsm.sv
module sram_bl_fsm
    import sram_bl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_sleep,
    input  logic              go_write,
    input  logic              go_read,
    input  logic              wide_mode,
    input  logic              half_sel,
    input  logic [LANES-1:0]  lane_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dout_en,
    output logic              standby
);

    acc_state_t        state;
    acc_state_t        nxt;
    logic [DATA_W-1:0] shaped;

    // Next state: sleep beats write, write beats read
    always_comb begin
        if (go_sleep) begin
            nxt = ST_STANDBY;
        end else if (go_write) begin
            nxt = ST_WRITE;
        end else if (go_read) begin
            nxt = ST_READ;
        end else begin
            nxt = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
        end else begin
            state <= nxt;
        end
    end

    // Read word shaping: mask undriven lanes, or move the chosen half down
    always_comb begin
        shaped = '0;
        if (wide_mode) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_rd[i]) begin
                    shaped[i*LANE_W +: LANE_W] = rd_data[i*LANE_W +: LANE_W];
                end
            end
        end else begin
            shaped[LANE_W-1:0] = rd_data[half_sel*LANE_W +: LANE_W];
        end
    end

    // Output process: registered data and lane enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= '0;
        end else begin
            unique case (nxt)
                ST_READ: begin
                    dout    <= shaped;
                    dout_en <= lane_rd;
                end
                ST_WRITE, ST_IDLE, ST_STANDBY: begin
                    dout    <= '0;
                    dout_en <= '0;
                end
            endcase
        end
    end

    assign standby = (state == ST_STANDBY);

endmodule

// File: rtl/sram_bytelane_top.sv
module sram_bytelane_top
    import sram_bl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en,
    output logic              standby
);

    logic [LANES-1:0]  lane_wr;
    logic [LANES-1:0]  lane_rd;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              half_sel;
    logic              go_sleep;
    logic              go_write;
    logic              go_read;

    sram_bl_decode u_decode (
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lo_n      (lo_n),
        .hi_n      (hi_n),
        .wide_mode (wide_mode),
        .din       (din),
        .lane_wr   (lane_wr),
        .lane_rd   (lane_rd),
        .wr_data   (wr_data),
        .half_sel  (half_sel),
        .go_sleep  (go_sleep),
        .go_write  (go_write),
        .go_read   (go_read)
    );

    sram_bl_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .lane_wr (lane_wr),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    sram_bl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_sleep  (go_sleep),
        .go_write  (go_write),
        .go_read   (go_read),
        .wide_mode (wide_mode),
        .half_sel  (half_sel),
        .lane_rd   (lane_rd),
        .rd_data   (rd_data),
        .dout      (dout),
        .dout_en   (dout_en),
        .standby   (standby)
    );

endmodule

// File: rtl/sram_bytelane_checks.sv
module sram_bytelane_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        cs1_n,
    input logic        cs2,
    input logic        oe_n,
    input logic        we_n,
    input logic        lo_n,
    input logic        hi_n,
    input logic        wide_mode,
    input logic [15:0] dout,
    input logic [1:0]  dout_en,
    input logic        standby
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |=> (dout_en == 2'b00 && standby)); // R1

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && !we_n) |=> (dout_en == 2'b00)); // R9

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dout_en == 2'b00)); // R4

    AST_LANE_LO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && lo_n) |=> !dout_en[0]); // R3

    AST_LANE_HI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && hi_n) |=> !dout_en[1]); // R3

    AST_LANE_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && !oe_n && we_n && wide_mode && !lo_n) |=> dout_en[0]); // R3

    AST_DARK_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en[0] |-> (dout[7:0] == 8'h00)); // R3

    AST_DARK_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en[1] |-> (dout[15:8] == 8'h00)); // R3

    AST_BOTH_OFF_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && lo_n && hi_n) |=> (standby && dout_en == 2'b00)); // R5

    AST_BYTE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |=> !dout_en[1]); // R8

    AST_BYTE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && !wide_mode) |=> !standby); // R8

endmodule

bind sram_bytelane_top sram_bytelane_checks i_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .lo_n      (lo_n),
    .hi_n      (hi_n),
    .wide_mode (wide_mode),
    .dout      (dout),
    .dout_en   (dout_en),
    .standby   (standby)
);

// File: tb/test_sram_bytelane_top.sv
`timescale 1ns/1ps
module test_sram_bytelane_top;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b1, cs2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic          lo_n = 1'b1, hi_n = 1'b1, wide_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;
    logic          standby;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] ref_mem [2*WORDS];

    always #2.5 clk = ~clk;

    sram_bytelane_top #(.ADDR_W(AW)) i_sram_bytelane_top (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n),
        .we_n(we_n), .lo_n(lo_n), .hi_n(hi_n), .wide_mode(wide_mode),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .standby(standby)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] pat(input int a, input int salt);
        logic [7:0] lo, hi;
        lo = 8'((a * 29 + 65 + salt * 17) & 255);
        hi = 8'((a * 13 + 7 + salt * 91) & 255);
        return {hi, lo};
    endfunction

    task automatic word_write(input int a, input logic [15:0] d, input logic l_n, input logic h_n);
        cs1_n = 0; cs2 = 1; wide_mode = 1; we_n = 0; oe_n = 1;
        lo_n = l_n; hi_n = h_n; addr = AW'(a); din = d;
        if (!l_n) ref_mem[2*a] = d[7:0];
        if (!h_n) ref_mem[2*a+1] = d[15:8];
        tick();
    endtask

    task automatic word_read_check(input int a, input logic l_n, input logic h_n, input string tag);
        logic [15:0] exp;
        cs1_n = 0; cs2 = 1; wide_mode = 1; we_n = 1; oe_n = 0;
        lo_n = l_n; hi_n = h_n; addr = AW'(a); din = 16'hDEAD;
        tick();
        exp = {h_n ? 8'h00 : ref_mem[2*a+1], l_n ? 8'h00 : ref_mem[2*a]};
        check({tag, " data"}, 32'(dout), 32'(exp));
        check({tag, " lanes"}, 32'(dout_en), 32'({!h_n, !l_n}));
    endtask

    task automatic byte_write(input int ba, input logic [7:0] d, input logic [6:0] junk);
        cs1_n = 0; cs2 = 1; wide_mode = 0; we_n = 0; oe_n = 1;
        lo_n = 1; hi_n = 1;
        addr = AW'(ba >> 1); din = {1'(ba & 1), junk, d};
        ref_mem[ba] = d;
        tick();
    endtask

    task automatic byte_read_check(input int ba, input logic l_n, input logic h_n);
        cs1_n = 0; cs2 = 1; wide_mode = 0; we_n = 1; oe_n = 0;
        lo_n = l_n; hi_n = h_n;
        addr = AW'(ba >> 1); din = {1'(ba & 1), 15'h2A5A};
        tick();
        check("R7 byte read data", 32'(dout), 32'({8'h00, ref_mem[ba]}));
        check("R8 byte read lanes", 32'(dout_en), 32'h1);
        check("R8 byte selected awake", 32'(standby), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 reset dout", 32'(dout), 32'h0);
        check("R10 reset dout_en", 32'(dout_en), 32'h0);
        check("R10 reset standby", 32'(standby), 32'h1);
        rst_n = 1;
        tick();

        // R6 R2 full word-mode fill and readback
        for (int a = 0; a < WORDS; a++) begin
            word_write(a, pat(a, 0), 1'b0, 1'b0);
            check("R4 write in progress dark", 32'(dout_en), 32'h0);
            check("R5 active write awake", 32'(standby), 32'h0);
        end
        for (int a = 0; a < WORDS; a++) word_read_check(a, 1'b0, 1'b0, "R6 word read");

        // R2 partial-lane writes keep the other lane
        for (int a = 0; a < WORDS; a++) begin
            if (a % 2 == 0) word_write(a, pat(a, 1), 1'b0, 1'b1);
            else            word_write(a, pat(a, 2), 1'b1, 1'b0);
        end
        for (int a = 0; a < WORDS; a++) word_read_check(a, 1'b0, 1'b0, "R2 lane write");

        // R3 single-lane reads
        for (int a = 0; a < 8; a++) begin
            word_read_check(a, 1'b0, 1'b1, "R3 low lane only");
            word_read_check(a, 1'b1, 1'b0, "R3 high lane only");
        end

        // R1 deselected writes have no effect
        cs1_n = 1; cs2 = 1; we_n = 0; oe_n = 0; lo_n = 0; hi_n = 0; addr = 3; din = 16'hFFFF;
        tick();
        check("R1 cs1_n high dark", 32'(dout_en), 32'h0);
        check("R1 cs1_n high standby", 32'(standby), 32'h1);
        cs1_n = 0; cs2 = 0; addr = 4;
        tick();
        check("R1 cs2 low dark", 32'(dout_en), 32'h0);
        check("R1 cs2 low standby", 32'(standby), 32'h1);
        word_read_check(3, 1'b0, 1'b0, "R1 deselected write ignored");
        word_read_check(4, 1'b0, 1'b0, "R1 deselected write ignored");

        // R4 output enable high, R5 both lanes off
        cs1_n = 0; cs2 = 1; we_n = 1; oe_n = 1; lo_n = 0; hi_n = 0; addr = 5;
        tick();
        check("R4 oe_n high dark", 32'(dout_en), 32'h0);
        check("R5 idle awake", 32'(standby), 32'h0);
        oe_n = 0; lo_n = 1; hi_n = 1;
        tick();
        check("R4 both lanes off dark", 32'(dout_en), 32'h0);
        check("R5 both lanes off standby", 32'(standby), 32'h1);

        // R9 write wins over read
        cs1_n = 0; cs2 = 1; we_n = 0; oe_n = 0; lo_n = 0; hi_n = 0; addr = 9; din = 16'hC3A5;
        ref_mem[18] = 8'hA5; ref_mem[19] = 8'hC3;
        tick();
        check("R9 overlap dark", 32'(dout_en), 32'h0);
        word_read_check(9, 1'b0, 1'b0, "R9 overlap wrote");

        // R7 R8 byte-mode sweep with ignored pins toggling
        for (int b = 0; b < 2*WORDS; b++) begin
            byte_write(b, 8'((b * 37 + 11) & 255), 7'(b * 5));
            check("R8 byte write awake", 32'(standby), 32'h0);
        end
        for (int b = 0; b < 2*WORDS; b++) byte_read_check(b, 1'(b & 1), 1'((b >> 1) & 1));

        // R7 byte layout seen through word mode
        for (int a = 0; a < WORDS; a += 5) word_read_check(a, 1'b0, 1'b0, "R7 byte halves in word");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule